// File: doc/BRIEF.md
# Key-Gated Input/Output Steering Wrapper

This block sits around a protected core and decides where system traffic goes. By default every input word flows to the core and the core's result drives the system output, with no key needed. A separate key port, qualified by a valid strobe, is compared against a stored constant. When a presented key matches, a single route register flips. From then on, input words are steered to a side authentication engine, and the system output is taken from that engine.

The route register returns to the core path when the engine signals completion with a done pulse, or on synchronous reset. A fresh matching key is then needed to divert the traffic again. The input demultiplexer and the output multiplexer share that one route register, so the input side and the output side can never point at different destinations. Whichever destination is not selected sees an all-zero input bus. Key width, stored key value and data width are parameters. The defaults are 8, 8'b1000_0000 and 8.

Top module: `keyed_route_wrap`

## Requirements
- R1: While `rst` is high at a rising edge, the route after that edge is the core path: `core_din` equals `sys_din` and `sys_dout` equals `core_dout`.
- R2: At a rising edge with `key_vld` high and `key_din` equal to 8'b1000_0000, the route becomes the engine path. The change is visible from that edge on, for the next input word.
- R3: A key presented with `key_vld` high that differs from 8'b1000_0000 leaves the route unchanged, in either path.
- R4: A key value on `key_din` while `key_vld` is low has no effect on the route.
- R5: On the engine path, `eng_din` equals `sys_din` and `sys_dout` equals `eng_dout`.
- R6: The destination that is not selected receives all zeros. On the core path this is `eng_din`; on the engine path it is `core_din`.
- R7: On the engine path, `eng_done` high at a rising edge returns the route to the core path after that edge.
- R8: `eng_done` while on the core path has no effect on the route.
- R9: On the engine path, if `eng_done` and a matching key arrive at the same edge, the done pulse wins and the route returns to the core path.
- R10: A synchronous reset taken while on the engine path returns the route to the core path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_din | input | KEY_W | Key value presented on the test port |
| key_vld | input | 1 | Qualifies `key_din` for one edge |
| sys_din | input | DATA_W | System input word |
| sys_dout | output | DATA_W | System output word |
| core_din | output | DATA_W | Input bus to the protected core |
| core_dout | input | DATA_W | Result bus from the protected core |
| eng_din | output | DATA_W | Input bus to the authentication engine |
| eng_dout | input | DATA_W | Result bus from the authentication engine |
| eng_done | input | 1 | Engine finished; releases the route |

## Verification
On every cycle, the assertions check the following:
- a qualified key hit moves the route to the engine;
- the absence of a hit holds the core route;
- done clears the engine route;
- reset forces the core route;
- both buses steer consistently with the route, and the idle destination sees zero.

Some behaviour only the bench scenarios can show, because each needs a particular sequence of stimulus to be driven first:
- a matching key with the strobe low does nothing;
- done arriving on the core path does nothing;
- done and key arriving at the same edge, where done wins;
- re-arming after release.

The bench compares every output against a behavioural route model on every cycle, and tags each comparison with the scenario's requirement.

// File: rtl/keyroute_pkg.sv
package keyroute_pkg;

  typedef enum logic {
    ROUTE_CORE = 1'b0,
    ROUTE_ENG  = 1'b1
  } route_e;

  // Next route: release by done has priority over a fresh key hit.
  function automatic route_e next_route(route_e cur, logic hit, logic done);
    route_e nxt;
    nxt = cur;
    if (cur == ROUTE_ENG) begin
      if (done) nxt = ROUTE_CORE;
    end else if (hit) begin
      nxt = ROUTE_ENG;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/key_gate.sv
module key_gate #(
  parameter int          KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY_VALUE = 8'b1000_0000
) (
  input  logic [KEY_W-1:0] key_din,
  input  logic             key_vld,
  output logic             key_hit
);

  function automatic logic key_equal(logic [KEY_W-1:0] a, logic [KEY_W-1:0] b);
    logic [KEY_W-1:0] diff;
    diff = a ^ b;
    return (diff == '0);
  endfunction

  logic key_same;

  assign key_same = key_equal(key_din, KEY_VALUE);
  assign key_hit  = key_vld & key_same;

endmodule

// File: rtl/route_reg.sv
module route_reg
  import keyroute_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   key_hit,
  input  logic   eng_done,
  output route_e route_q
);

  route_e route_d;

  assign route_d = next_route(route_q, key_hit, eng_done);

  always_ff @(posedge clk) begin
    if (rst) route_q <= ROUTE_CORE;
    else     route_q <= route_d;
  end

endmodule

// File: rtl/bus_demux.sv
module bus_demux #(
  parameter int DATA_W = 8,
  parameter int N_DST  = 2,
  localparam int SEL_W = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout [N_DST]
);

  for (genvar g = 0; g < N_DST; g++) begin : g_dst
    assign dout[g] = (sel == SEL_W'(g)) ? din : '0;
  end

endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din [N_SRC],
  output logic [DATA_W-1:0] dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) dout = din[i];
    end
  end

endmodule

// File: rtl/keyed_route_wrap.sv
module keyed_route_wrap
  import keyroute_pkg::*;
#(
  parameter int               KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY_VALUE = 8'b1000_0000,
  parameter int               DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key_din,
  input  logic              key_vld,
  input  logic [DATA_W-1:0] sys_din,
  output logic [DATA_W-1:0] sys_dout,
  output logic [DATA_W-1:0] core_din,
  input  logic [DATA_W-1:0] core_dout,
  output logic [DATA_W-1:0] eng_din,
  input  logic [DATA_W-1:0] eng_dout,
  input  logic              eng_done
);

  localparam int N_PATH = 2;
  localparam int IDX_CORE = 0;
  localparam int IDX_ENG  = 1;

  logic              key_hit;
  route_e            route_q;
  logic              to_engine;
  logic [0:0]        path_sel;
  logic [DATA_W-1:0] dmx_out [N_PATH];
  logic [DATA_W-1:0] mux_in  [N_PATH];

  key_gate #(
    .KEY_W     (KEY_W),
    .KEY_VALUE (KEY_VALUE)
  ) u_key_gate (
    .key_din (key_din),
    .key_vld (key_vld),
    .key_hit (key_hit)
  );

  route_reg u_route_reg (
    .clk      (clk),
    .rst      (rst),
    .key_hit  (key_hit),
    .eng_done (eng_done),
    .route_q  (route_q)
  );

  assign to_engine = (route_q == ROUTE_ENG);
  assign path_sel  = to_engine;

  bus_demux #(
    .DATA_W (DATA_W),
    .N_DST  (N_PATH)
  ) u_demux (
    .sel  (path_sel),
    .din  (sys_din),
    .dout (dmx_out)
  );

  assign core_din = dmx_out[IDX_CORE];
  assign eng_din  = dmx_out[IDX_ENG];

  assign mux_in[IDX_CORE] = core_dout;
  assign mux_in[IDX_ENG]  = eng_dout;

  bus_mux #(
    .DATA_W (DATA_W),
    .N_SRC  (N_PATH)
  ) u_mux (
    .sel  (path_sel),
    .din  (mux_in),
    .dout (sys_dout)
  );

endmodule

// File: rtl/keyed_route_chk.sv
module keyed_route_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              key_hit,
  input logic              eng_done,
  input logic              to_engine,
  input logic [DATA_W-1:0] sys_din,
  input logic [DATA_W-1:0] sys_dout,
  input logic [DATA_W-1:0] core_din,
  input logic [DATA_W-1:0] core_dout,
  input logic [DATA_W-1:0] eng_din,
  input logic [DATA_W-1:0] eng_dout
);

  p_reset_core_r1: assert property (@(posedge clk) rst |=> !to_engine)
    else $error("R1 route not core after reset");

  p_hit_arms_r2: assert property (@(posedge clk) disable iff (rst)
    (key_hit && !to_engine) |=> to_engine)
    else $error("R2 matching key did not select engine");

  p_no_hit_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!key_hit && !to_engine) |=> !to_engine)
    else $error("R3 route left core without a key hit");

  p_engine_steer_r5: assert property (@(posedge clk) disable iff (rst)
    to_engine |-> (eng_din == sys_din && sys_dout == eng_dout))
    else $error("R5 engine path steering wrong");

  p_core_steer_r1: assert property (@(posedge clk) disable iff (rst)
    !to_engine |-> (core_din == sys_din && sys_dout == core_dout))
    else $error("R1 core path steering wrong");

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    to_engine ? (core_din == '0) : (eng_din == '0))
    else $error("R6 idle destination not zero");

  p_done_release_r7: assert property (@(posedge clk) disable iff (rst)
    (to_engine && eng_done) |=> !to_engine)
    else $error("R7 done did not release route");

  p_engine_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (to_engine && !eng_done) |=> to_engine)
    else $error("R3 engine route dropped without done");

endmodule

bind keyed_route_wrap keyed_route_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_hit   (key_hit),
  .eng_done  (eng_done),
  .to_engine (to_engine),
  .sys_din   (sys_din),
  .sys_dout  (sys_dout),
  .core_din  (core_din),
  .core_dout (core_dout),
  .eng_din   (eng_din),
  .eng_dout  (eng_dout)
);

// File: tb/test_keyed_route_wrap.sv
module test_keyed_route_wrap;

  localparam int KW = 8;
  localparam int DW = 8;
  localparam logic [KW-1:0] GOOD_KEY = 8'b1000_0000;

  logic          clk = 1'b0;
  logic          rst;
  logic [KW-1:0] key_din;
  logic          key_vld;
  logic [DW-1:0] sys_din, sys_dout, core_din, core_dout, eng_din, eng_dout;
  logic          eng_done;

  int total = 0;
  int bad   = 0;
  bit model_eng = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  keyed_route_wrap i_keyed_route_wrap (
    .clk (clk), .rst (rst), .key_din (key_din), .key_vld (key_vld),
    .sys_din (sys_din), .sys_dout (sys_dout),
    .core_din (core_din), .core_dout (core_dout),
    .eng_din (eng_din), .eng_dout (eng_dout), .eng_done (eng_done)
  );

  // Behavioural route model from the requirements.
  always @(posedge clk) begin
    if (rst)                      model_eng = 1'b0;
    else if (model_eng)           begin if (eng_done) model_eng = 1'b0; end
    else if (key_vld && key_din == GOOD_KEY) model_eng = 1'b1;
  end

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (model_eng) begin
      check("eng_din (R5)",  eng_din,  sys_din);
      check("sys_dout (R5)", sys_dout, eng_dout);
      check("core_din (R6)", core_din, '0);
    end else begin
      check("core_din (R1)", core_din, sys_din);
      check("sys_dout (R1)", sys_dout, core_dout);
      check("eng_din (R6)",  eng_din,  '0);
    end
  endtask

  task automatic step(bit r, logic [KW-1:0] k, bit kv, bit d);
    @(negedge clk);
    rst = r; key_din = k; key_vld = kv; eng_done = d;
    sys_din = DW'($urandom); core_dout = DW'($urandom); eng_dout = DW'($urandom);
    #2;
    compare_all();
  endtask

  task automatic expect_route(bit exp_eng);
    total++;
    if (model_eng !== exp_eng) begin
      bad++;
      $display("FAIL %s route model: actual=%0d expected=%0d", tag, model_eng, exp_eng);
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; key_din = '0; key_vld = 1'b0; eng_done = 1'b0;
    sys_din = '0; core_dout = '0; eng_dout = '0;
    tag = "R1";
    repeat (3) step(1, 8'h00, 0, 0);
    repeat (3) step(0, 8'h00, 0, 0);

    tag = "R4";  // good key without strobe
    step(0, GOOD_KEY, 0, 0); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R3";  // near-miss keys
    step(0, 8'h81, 1, 0); step(0, 8'h00, 1, 0); step(0, 8'h40, 1, 0);
    step(0, 8'hFF, 1, 0); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R8";
    step(0, 8'h00, 0, 1); step(0, 8'h00, 0, 1); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R2";
    step(0, GOOD_KEY, 1, 0);
    step(0, 8'h00, 0, 0);
    expect_route(1);
    tag = "R5";
    repeat (4) step(0, 8'h00, 0, 0);

    tag = "R3";  // mismatch on engine path keeps it
    step(0, 8'h7F, 1, 0); step(0, GOOD_KEY, 1, 0); step(0, 8'h00, 0, 0);
    expect_route(1);

    tag = "R7";
    step(0, 8'h00, 0, 1); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R9";
    step(0, GOOD_KEY, 1, 0); step(0, GOOD_KEY, 1, 1); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R10";
    step(0, GOOD_KEY, 1, 0); step(0, 8'h00, 0, 0);
    expect_route(1);
    step(1, 8'h00, 0, 0); step(0, 8'h00, 0, 0);
    expect_route(0);

    tag = "R2";  // random traffic with occasional keys and done
    for (int i = 0; i < 400; i++) begin
      logic [KW-1:0] k;
      k = ($urandom_range(0, 3) == 0) ? GOOD_KEY : KW'($urandom);
      step(($urandom_range(0, 63) == 0), k, $urandom_range(0, 1),
           ($urandom_range(0, 7) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule